// File: doc/BRIEF.md
# Nibble-Serial Clock-Chip Register Access Master

This block carries out one register access at a time to a real-time-clock chip over a three-wire serial link. The three wires are a serial clock, one bidirectional data line and a chip-enable. The chip-enable is driven elsewhere. A user asserts `start_i` for one cycle with a read/write flag, a 4-bit register address and, for writes, a 4-bit data value. The block then shifts out a 16-bit frame made of nibbles. Each nibble goes out most significant bit first. The block returns a one-cycle `done_o` pulse. For reads, the captured nibble appears on `rdata_o`.

Every frame opens with a control nibble. For a read the control nibble is 1,1,1,0 and for a write it is 1,0,1,0, sent in that order. The bits are a filler bit driven as 1, the read flag, the address-phase flag and the data-phase flag. The address nibble follows.

A write then sends the data-phase control nibble 1,0,0,1 and the data nibble. A read releases the data line after the address and clocks in eight bits. It discards the first four and keeps the last four. The bidirectional line appears as three signals: `sio_o`, `sio_i` and the drive enable `sio_oe_o`.

Each bit has a high phase of `HALF_CYC` clocks followed by a low phase of `HALF_CYC` clocks. Output data changes at the start of the high phase. Input data is sampled in the last clock of the high phase.

The controller has four states:
- `ST_IDLE`: the serial clock is high and the line is driven to 1.
- `ST_HIGH`: the high phase of a bit.
- `ST_LOW`: the low phase of a bit.
- `ST_DONE`: a single cycle that drives the done pulse.

The transitions are:
- IDLE→HIGH when a start is accepted.
- HIGH→LOW when the half-period timer expires.
- LOW→HIGH when the timer expires on any bit but the last.
- LOW→DONE when the timer expires on bit 15.
- DONE→IDLE unconditionally.

Top module: `rtc_nibble_master`

## Requirements
- R1: Out of reset and whenever idle, `sclk_o`=1, `sio_oe_o`=1, `sio_o`=1 and `done_o`=0. After reset `rdata_o`=0.
- R2: Every frame has 16 serial-clock pulses. Its first eight bits, in order, are 1, R (1 read, 0 write), 1, 0 and then address bits 3,2,1,0.
- R3: In a write, bits 8..15 are 1, 0, 0, 1 and then data bits 3,2,1,0. `sio_oe_o` stays 1 for the whole frame.
- R4: In a read, `sio_oe_o` is 1 during bits 0..7 and 0 during bits 8..15. It falls while `sclk_o` is high and rises again in the `done_o` cycle.
- R5: In a read, the values on `sio_i` during bits 8..11 are ignored. The values during bits 12..15 become `rdata_o[3]..rdata_o[0]`. Each bit is sampled in the last clock of its high phase.
- R6: Each low phase of `sclk_o` lasts exactly `HALF_CYC` clocks and each high phase within a frame lasts `HALF_CYC` clocks. `sio_o` changes only while `sclk_o` is high.
- R7: `done_o` is one clock wide. It is high in the first cycle after the final low phase, which is 32·`HALF_CYC`+1 clocks after the cycle in which `start_i` was accepted.
- R8: `start_i` has no effect unless the block is idle. Address, data and direction are latched when a start is accepted.
- R9: `rdata_o` changes only in a cycle with `done_o` high after a read. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Last nibble read, held until the next read completes |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock, idles high |
| sio_o | output | 1 | Serial data output value |
| sio_i | input | 1 | Serial data input value |
| sio_oe_o | output | 1 | Serial data drive enable (1 = driving) |

## Verification
The bench uses a `HALF_CYC` of 3, so `done_o` is due 97 clocks after the clock edge that accepts `start_i`. The driver stamps each queued item with that cycle number, and the monitor compares the cycle in which it sees `done_o` against the stamp.

Serial bits and drive-enable values are captured at each falling edge of `sclk_o`, because the data is stable through the whole high phase before that edge. The bench drives its reply bit for read bits 8..15 during the preceding low phase, ahead of the sampling clock.

Read data and held data are compared only in the `done_o` cycle. All outputs are sampled on the falling system-clock edge.

// File: rtl/rtcn_pkg.sv
package rtcn_pkg;

    localparam int NIB_W       = 4;
    localparam int FRAME_BITS  = 4 * NIB_W;
    localparam int RD_OUT_BITS = 2 * NIB_W;

    // filler, read flag, address phase, data phase
    localparam logic [NIB_W-1:0] CTRL_RD      = 4'b1110;
    localparam logic [NIB_W-1:0] CTRL_WR_ADDR = 4'b1010;
    localparam logic [NIB_W-1:0] CTRL_WR_DATA = 4'b1001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_DONE = 2'd3
    } rtcn_state_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic             rd,
        input logic [NIB_W-1:0] addr,
        input logic [NIB_W-1:0] data
    );
        if (rd)
            return {CTRL_RD, addr, {RD_OUT_BITS{1'b1}}};
        else
            return {CTRL_WR_ADDR, addr, CTRL_WR_DATA, data};
    endfunction

endpackage

// File: rtl/rtcn_half_timer.sv
module rtcn_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtcn_tx_shift.sv
module rtcn_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    assign msb = sr_q[W-1];

    // ones are shifted in so the line rests at 1 after a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '1;
        else if (load)
            sr_q <= load_val;
        else if (shift)
            sr_q <= {sr_q[W-2:0], 1'b1};
    end
endmodule

// File: rtl/rtcn_rx_shift.sv
module rtcn_rx_shift #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/rtc_nibble_master.sv
module rtc_nibble_master
    import rtcn_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic [NIB_W-1:0] addr_i,
    input  logic [NIB_W-1:0] wdata_i,
    output logic [NIB_W-1:0] rdata_o,
    output logic             done_o,
    output logic             sclk_o,
    output logic             sio_o,
    input  logic             sio_i,
    output logic             sio_oe_o
);
    localparam int BCW = $clog2(FRAME_BITS);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);
    localparam logic [BCW-1:0] FIRST_IN = BCW'(RD_OUT_BITS);

    rtcn_state_e state_q, state_d;
    logic [BCW-1:0]        bit_q;
    logic                  rd_q;
    logic [NIB_W-1:0]      rdata_q;
    logic [NIB_W-1:0]      rx_q;
    logic [FRAME_BITS-1:0] frame_w;
    logic                  tick, accept, bit_end, sample, in_phase, active, tx_bit;

    assign active   = (state_q == ST_HIGH) || (state_q == ST_LOW);
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign in_phase = rd_q && (bit_q >= FIRST_IN);
    assign bit_end  = (state_q == ST_LOW) && tick;
    assign sample   = (state_q == ST_HIGH) && tick && in_phase;
    assign frame_w  = build_frame(rd_i, addr_i, wdata_i);

    rtcn_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!active),
        .tick  (tick)
    );

    rtcn_tx_shift #(.W(FRAME_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (frame_w),
        .shift    (bit_end),
        .msb      (tx_bit)
    );

    rtcn_rx_shift #(.W(NIB_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample),
        .din   (sio_i),
        .q     (rx_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_HIGH;
            ST_HIGH: if (tick)    state_d = ST_LOW;
            ST_LOW:  if (tick)    state_d = (bit_q == LAST_BIT) ? ST_DONE : ST_HIGH;
            ST_DONE:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            rd_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_q <= '0;
                rd_q  <= rd_i;
            end else if (bit_end) begin
                bit_q <= bit_q + 1'b1;
            end
            if (bit_end && (bit_q == LAST_BIT) && rd_q)
                rdata_q <= rx_q;
        end
    end

    always_comb begin
        sclk_o   = (state_q != ST_LOW);
        sio_oe_o = !(active && in_phase);
        done_o   = (state_q == ST_DONE);
        sio_o    = tx_bit;
        rdata_o  = rdata_q;
    end
endmodule

// File: rtl/rtcn_checker.sv
module rtcn_checker #(
    parameter int HALF_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] rdata_o,
    input logic       done_o,
    input logic       sclk_o,
    input logic       sio_o,
    input logic       sio_oe_o
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= 0;
        else if (!sclk_o)
            low_cnt <= low_cnt + 1;
        else
            low_cnt <= 0;
    end

    // R6
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (low_cnt == HALF_CYC));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sio_o) |-> sclk_o);

    // R7
    done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sclk_o && sio_oe_o && sio_o));

    // R4
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sio_oe_o) |-> sclk_o);

    // R4
    redrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sio_oe_o) |-> done_o);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> done_o);
endmodule

bind rtc_nibble_master rtcn_checker #(.HALF_CYC(HALF_CYC)) u_chk (.*);

// File: tb/rtc_nibble_master_tb.sv
module rtc_nibble_master_tb;
    localparam int HALF  = 3;
    localparam int FBITS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, rd_i = 1'b0, sio_i = 1'b0;
    logic [3:0] addr_i = '0, wdata_i = '0;
    logic [3:0] rdata_o;
    logic       done_o, sclk_o, sio_o, sio_oe_o;

    always #5 clk = ~clk;

    rtc_nibble_master #(.HALF_CYC(HALF)) u_dut (.*);

    typedef struct {
        logic       rd;
        logic [7:0] inbits;
        logic [15:0] frame;
        logic [3:0] rdata;
        longint     done_cyc;
    } item_t;

    item_t  q[$];
    int     checks = 0, errors = 0;
    longint cyc = 0;
    logic [3:0] last_rd = 4'h0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // driver: pushes the expected result, then pulses start
    task automatic access(logic rd, logic [3:0] a, logic [3:0] d, logic [7:0] inb, bit intrude);
        item_t it;
        it.rd     = rd;
        it.inbits = inb;
        it.frame  = rd ? {4'b1110, a, 8'h00} : {4'b1010, a, 4'b1001, d};
        if (rd) last_rd = inb[3:0];
        it.rdata  = last_rd;
        @(negedge clk);
        it.done_cyc = cyc + 1 + 2 * HALF * FBITS;
        q.push_back(it);
        rd_i = rd; addr_i = a; wdata_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (intrude) begin
            repeat (20) @(negedge clk);
            rd_i = ~rd; addr_i = ~a; wdata_i = ~d; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // monitor
    logic [15:0] fr = '0, oer = '0;
    int          nfall = 0, lowcnt = 0;
    logic        prev_sclk = 1'b1, prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sclk_o) lowcnt++;
            if (prev_sclk && !sclk_o) begin
                fr  = {fr[14:0], sio_o};
                oer = {oer[14:0], sio_oe_o};
                nfall++;
                if (q.size() > 0 && nfall >= 8 && nfall < 16)
                    sio_i = q[0].inbits[15 - nfall];
                else
                    sio_i = 1'b0;
            end
            if (prev_done && done_o) check("R7 done width", 1, 0);
            if (done_o) begin
                if (q.size() == 0) begin
                    check("R8 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check("R2 control+address", fr[15:8], it.frame[15:8]);
                    check("R2 pulse count", nfall, FBITS);
                    check("R6 low cycles", lowcnt, FBITS * HALF);
                    check("R7 done cycle", cyc, it.done_cyc);
                    if (it.rd) begin
                        check("R4 drive enable", oer, 16'hFF00);
                        check("R5 read data", rdata_o, it.rdata);
                    end else begin
                        check("R3 write tail", fr[7:0], it.frame[7:0]);
                        check("R3 drive enable", oer, 16'hFFFF);
                        check("R9 held rdata", rdata_o, it.rdata);
                    end
                end
                fr = '0; oer = '0; nfall = 0; lowcnt = 0;
            end
            prev_sclk = sclk_o;
            prev_done = done_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sclk", sclk_o, 1);
        check("R1 oe", sio_oe_o, 1);
        check("R1 sio", sio_o, 1);
        check("R1 done", done_o, 0);
        check("R1 rdata", rdata_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        access(1'b0, 4'h3, 4'hA, 8'h00, 1'b0);
        access(1'b0, 4'hC, 4'h5, 8'h00, 1'b0);
        access(1'b1, 4'h5, 4'h0, 8'b1010_0110, 1'b0);   // R5 expect 6
        access(1'b0, 4'h0, 4'hF, 8'h00, 1'b0);          // R9 rdata stays 6
        access(1'b1, 4'hF, 4'h0, 8'b0101_1001, 1'b0);   // R5 expect 9
        check("R1 idle oe after read", sio_oe_o, 1);
        check("R1 idle sio after read", sio_o, 1);
        access(1'b1, 4'h8, 4'h0, 8'hF0, 1'b0);          // R5 discarded ones
        access(1'b0, 4'h6, 4'h9, 8'h00, 1'b1);          // R8 start while busy

        // R8: the start during the frame must not have launched a second frame
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            check("R8 no extra frame", sclk_o, 1);
        end
        check("R8 queue drained", q.size(), 0);
        check("R9 rdata after writes", rdata_o, 4'h0);
        summary();
    end
endmodule